// File: doc/BRIEF.md
# Recursive Split-Operand Multiplier

This block multiplies two unsigned operands of `WIDTH` bits and returns the full product of `2*WIDTH` bits. Each operand is cut into a low half and a high half. The four half-width products (low·low, low·high, high·low, high·high) come from the same multiplier structure, one level narrower, and the recursion stops at 2-bit operands. At that base width the product comes from AND gates and a half-adder network. The two cross products are added and moved up by `WIDTH/2` bit positions. The high product is moved up by `WIDTH` positions. Every term is zero-extended to the product width and all of them are summed.

It is used as a datapath multiplier. The result can be taken straight from the adder tree, or captured in an output register when `OUT_REG` is set. Elaboration stops with an error when `WIDTH` is not a power of two of at least 4.

Top module: `splitmul_top`

## Requirements
- R1: `product` equals `a*b` as an unsigned `2*WIDTH`-bit value, with no truncation, for all operand values.
- R2: The low-half term equals `a[WIDTH/2-1:0] * b[WIDTH/2-1:0]` and enters the product at weight 1.
- R3: The sum of the two cross terms (`a` low half times `b` high half, plus `a` high half times `b` low half) enters the product multiplied by 2^(WIDTH/2).
- R4: The high-half term enters the product multiplied by 2^WIDTH, and it is zero whenever either operand's high half is zero.
- R5: With `OUT_REG=1`, `rst_n` low asynchronously clears `product` to 0, and `product` stays 0 while `rst_n` is held low.
- R6: With `OUT_REG=1`, `product` shows the product of the operands present at the most recent rising edge of `clk`. A change of the operands between edges does not alter `product` until the next edge.
- R7: With `OUT_REG=0`, `product` follows the operands combinationally, and `clk` and `rst_n` have no effect on it.
- R8: All-ones operands give (2^WIDTH−1)^2 (0xFFFE0001 at WIDTH=16). A zero operand gives a zero product.
- R9: At WIDTH=4, a=0011 and b=1001 give the product 27. This is the low term 3, plus the cross term 6 shifted left by 2 (24), plus a high term of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| a | input | WIDTH | Unsigned multiplicand |
| b | input | WIDTH | Unsigned multiplier |
| product | output | 2*WIDTH | Unsigned product |

## Verification
A wrong sub-product anywhere in the recursion changes the product for every operand pair whose bits reach that sub-multiplier. The error shows at the port in the same cycle without the output register, or one edge later with it. Operands that are zero except in one half isolate the low, cross and high terms, so a bad shift or a missing term shows up as a product off by a power-of-two multiple. An 8-bit instance is swept over all operand pairs to expose faults in the 2-bit base cell or in carry handling inside the adder tree. All-ones operands drive the widest carries.

// File: rtl/splitmul_pkg.sv
`timescale 1ns/1ps
package splitmul_pkg;

  // True when v is a power of two and at least lim.
  function automatic bit is_pow2_min(int v, int lim);
    return (v >= lim) && ((v & (v - 1)) == 0);
  endfunction

  // 2x2 product from AND terms and two half adders.
  function automatic logic [3:0] mul2x2(logic [1:0] x, logic [1:0] y);
    logic t_lo, t_x1y0, t_x0y1, t_hi, s1, c1, s2, c2;
    t_lo   = x[0] & y[0];
    t_x1y0 = x[1] & y[0];
    t_x0y1 = x[0] & y[1];
    t_hi   = x[1] & y[1];
    s1 = t_x1y0 ^ t_x0y1;
    c1 = t_x1y0 & t_x0y1;
    s2 = t_hi ^ c1;
    c2 = t_hi & c1;
    return {c2, s2, s1, t_lo};
  endfunction

endpackage

// File: rtl/splitmul_base2.sv
`timescale 1ns/1ps
module splitmul_base2
  import splitmul_pkg::*;
(
  input  logic [1:0] x,
  input  logic [1:0] y,
  output logic [3:0] p
);
  assign p = mul2x2(x, y);
endmodule

// File: rtl/splitmul_combine.sv
`timescale 1ns/1ps
module splitmul_combine #(
  parameter int W = 16
) (
  input  logic [W-1:0]   ll,
  input  logic [W-1:0]   lh,
  input  logic [W-1:0]   hl,
  input  logic [W-1:0]   hh,
  output logic [2*W-1:0] cross_sh,
  output logic [2*W-1:0] p
);
  localparam int HALF = W / 2;
  localparam int PW   = 2 * W;

  logic [W:0]    cross_raw;
  logic [PW-1:0] ll_ext, cross_ext, hh_ext;

  assign cross_raw = {1'b0, lh} + {1'b0, hl};
  assign ll_ext    = {{W{1'b0}}, ll};
  assign cross_ext = {{(W-1){1'b0}}, cross_raw};
  assign cross_sh  = cross_ext << HALF;
  assign hh_ext    = {hh, {W{1'b0}}};
  assign p         = ll_ext + cross_sh + hh_ext;
endmodule

// File: rtl/splitmul_core.sv
`timescale 1ns/1ps
module splitmul_core #(
  parameter int W = 8
) (
  input  logic [W-1:0]   x,
  input  logic [W-1:0]   y,
  output logic [2*W-1:0] p
);
  localparam int HALF = W / 2;

  generate
    if (W == 2) begin : g_leaf
      splitmul_base2 u_leaf (.x(x), .y(y), .p(p));
    end else begin : g_split
      logic [W-1:0]   q_ll, q_lh, q_hl, q_hh;
      logic [2*W-1:0] unused_cross;
      splitmul_core #(.W(HALF)) u_ll (.x(x[HALF-1:0]), .y(y[HALF-1:0]), .p(q_ll));
      splitmul_core #(.W(HALF)) u_lh (.x(x[HALF-1:0]), .y(y[W-1:HALF]), .p(q_lh));
      splitmul_core #(.W(HALF)) u_hl (.x(x[W-1:HALF]), .y(y[HALF-1:0]), .p(q_hl));
      splitmul_core #(.W(HALF)) u_hh (.x(x[W-1:HALF]), .y(y[W-1:HALF]), .p(q_hh));
      splitmul_combine #(.W(W)) u_sum (
        .ll(q_ll), .lh(q_lh), .hl(q_hl), .hh(q_hh),
        .cross_sh(unused_cross), .p(p)
      );
    end
  endgenerate
endmodule

// File: rtl/splitmul_top.sv
`timescale 1ns/1ps
module splitmul_top
  import splitmul_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter bit OUT_REG = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WIDTH-1:0]   a,
  input  logic [WIDTH-1:0]   b,
  output logic [2*WIDTH-1:0] product
);
  localparam int HALF = WIDTH / 2;
  localparam int PW   = 2 * WIDTH;

  initial begin
    assert_width_legal: assert (is_pow2_min(WIDTH, 4))
      else $error("splitmul_top: WIDTH %0d must be a power of two >= 4", WIDTH);
  end

  // First-level split, brought out by name for the checker.
  logic [HALF-1:0]  a_lo, a_hi, b_lo, b_hi;
  logic [WIDTH-1:0] pp_ll, pp_lh, pp_hl, pp_hh;
  logic [PW-1:0]    cross_shifted, prod_comb;

  assign a_lo = a[HALF-1:0];
  assign a_hi = a[WIDTH-1:HALF];
  assign b_lo = b[HALF-1:0];
  assign b_hi = b[WIDTH-1:HALF];

  splitmul_core #(.W(HALF)) u_ll (.x(a_lo), .y(b_lo), .p(pp_ll));
  splitmul_core #(.W(HALF)) u_lh (.x(a_lo), .y(b_hi), .p(pp_lh));
  splitmul_core #(.W(HALF)) u_hl (.x(a_hi), .y(b_lo), .p(pp_hl));
  splitmul_core #(.W(HALF)) u_hh (.x(a_hi), .y(b_hi), .p(pp_hh));

  splitmul_combine #(.W(WIDTH)) u_sum (
    .ll(pp_ll), .lh(pp_lh), .hl(pp_hl), .hh(pp_hh),
    .cross_sh(cross_shifted), .p(prod_comb)
  );

  generate
    if (OUT_REG) begin : g_reg
      logic [PW-1:0] prod_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prod_q <= '0;
        else        prod_q <= prod_comb;
      end
      assign product = prod_q;
    end else begin : g_comb
      assign product = prod_comb;
    end
  endgenerate
endmodule

// File: rtl/splitmul_checker.sv
`timescale 1ns/1ps
module splitmul_checker #(
  parameter int WIDTH   = 16,
  parameter bit OUT_REG = 1'b1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [WIDTH-1:0]   a,
  input logic [WIDTH-1:0]   b,
  input logic [WIDTH/2-1:0] a_lo,
  input logic [WIDTH/2-1:0] a_hi,
  input logic [WIDTH/2-1:0] b_lo,
  input logic [WIDTH/2-1:0] b_hi,
  input logic [WIDTH-1:0]   pp_ll,
  input logic [WIDTH-1:0]   pp_hh,
  input logic [2*WIDTH-1:0] cross_shifted,
  input logic [2*WIDTH-1:0] prod_comb,
  input logic [2*WIDTH-1:0] product
);
  localparam int HALF = WIDTH / 2;
  localparam int PW   = 2 * WIDTH;

  logic [WIDTH-1:0] ref_ll;
  logic [PW-1:0]    ref_cross, ref_full;

  always_comb begin
    ref_ll    = WIDTH'(a_lo) * WIDTH'(b_lo);
    ref_cross = (PW'(a_lo) * PW'(b_hi) + PW'(a_hi) * PW'(b_lo)) << HALF;
    ref_full  = PW'(a) * PW'(b);
  end

  assert_full_product_R1: assert property (@(posedge clk) disable iff (!rst_n)
    prod_comb == ref_full);

  assert_low_term_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pp_ll == ref_ll);

  assert_cross_weight_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cross_shifted == ref_cross);

  assert_high_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (a_hi == '0 || b_hi == '0) |-> pp_hh == '0);

  generate
    if (OUT_REG) begin : g_reg_chk
      assert_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> product == PW'($past(a)) * PW'($past(b)));
    end else begin : g_comb_chk
      assert_passthrough_R7: assert property (@(posedge clk) disable iff (!rst_n)
        product == ref_full);
    end
  endgenerate
endmodule

bind splitmul_top splitmul_checker #(.WIDTH(WIDTH), .OUT_REG(OUT_REG)) u_chk (
  .clk(clk), .rst_n(rst_n), .a(a), .b(b),
  .a_lo(a_lo), .a_hi(a_hi), .b_lo(b_lo), .b_hi(b_hi),
  .pp_ll(pp_ll), .pp_hh(pp_hh),
  .cross_shifted(cross_shifted), .prod_comb(prod_comb), .product(product)
);

// File: tb/tb_splitmul_top.sv
`timescale 1ns/1ps
module tb_splitmul_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [15:0] a16 = '0, b16 = '0;
  logic [31:0] p16;
  logic [7:0]  a8 = '0, b8 = '0;
  logic [15:0] p8;
  logic [3:0]  a4 = '0, b4 = '0;
  logic [7:0]  p4;

  splitmul_top #(.WIDTH(16), .OUT_REG(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .a(a16), .b(b16), .product(p16));
  splitmul_top #(.WIDTH(8), .OUT_REG(1'b0)) dut8 (
    .clk(clk), .rst_n(rst_n), .a(a8), .b(b8), .product(p8));
  splitmul_top #(.WIDTH(4), .OUT_REG(1'b1)) dut4 (
    .clk(clk), .rst_n(rst_n), .a(a4), .b(b4), .product(p4));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Drive at negedge, let one rising edge pass, sample at the next negedge.
  task automatic apply16(logic [15:0] x, logic [15:0] y);
    @(negedge clk);
    a16 = x; b16 = y;
    @(negedge clk);
  endtask

  task automatic t_reset();
    #1;
    chk("R5 reset clears", 64'(p16), 64'd0);
    a16 = 16'hFFFF; b16 = 16'hFFFF; a4 = 4'hF; b4 = 4'hF;
    a8 = 8'd12; b8 = 8'd11;
    repeat (2) @(negedge clk);
    chk("R5 held during reset", 64'(p16), 64'd0);
    chk("R5 held during reset w4", 64'(p4), 64'd0);
    chk("R7 comb ignores reset", 64'(p8), 64'd132);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 first edge after reset", 64'(p16), 64'hFFFE0001);
  endtask

  task automatic t_halves();
    apply16(16'h00B7, 16'h00E5);
    chk("R2 low halves only", 64'(p16), 64'(32'hB7 * 32'hE5));
    apply16(16'h00C3, 16'h5A00);
    chk("R3 cross a_lo*b_hi", 64'(p16), 64'((32'hC3 * 32'h5A) << 8));
    apply16(16'h7100, 16'h0029);
    chk("R3 cross a_hi*b_lo", 64'(p16), 64'((32'h71 * 32'h29) << 8));
    apply16(16'hF300, 16'h9D00);
    chk("R4 high halves only", 64'(p16), 64'((32'hF3 * 32'h9D) << 16));
    apply16(16'h00FF, 16'hABCD);
    chk("R4 zero high half of a", 64'(p16), 64'(32'hFF * 32'hABCD));
  endtask

  task automatic t_extremes();
    apply16(16'hFFFF, 16'hFFFF);
    chk("R8 all ones", 64'(p16), 64'hFFFE0001);
    apply16(16'h0000, 16'hFFFF);
    chk("R8 zero operand", 64'(p16), 64'd0);
    apply16(16'h8000, 16'h8000);
    chk("R1 top bits", 64'(p16), 64'h40000000);
  endtask

  task automatic t_latency();
    apply16(16'd1234, 16'd567);
    @(negedge clk);
    a16 = 16'd999; b16 = 16'd3;
    #2;
    chk("R6 holds until edge", 64'(p16), 64'(32'd1234 * 32'd567));
    @(negedge clk);
    chk("R6 updates after edge", 64'(p16), 64'd2997);
  endtask

  task automatic t_example4();
    @(negedge clk);
    a4 = 4'b0011; b4 = 4'b1001;
    @(negedge clk);
    chk("R9 worked example", 64'(p4), 64'd27);
    a4 = 4'hF; b4 = 4'hF;
    @(negedge clk);
    chk("R8 all ones w4", 64'(p4), 64'd225);
  endtask

  task automatic t_exhaustive8();
    int bad = 0;
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j++) begin
        @(negedge clk);
        a8 = 8'(i); b8 = 8'(j);
        #1;
        if (p8 !== 16'(i * j)) begin
          bad++;
          if (bad <= 4) chk("R1 R7 exhaustive w8", 64'(p8), 64'(i * j));
        end
      end
    end
    chk("R1 R7 exhaustive mismatch count", 64'(bad), 64'd0);
  endtask

  task automatic t_random();
    int bad = 0;
    for (int k = 0; k < 3000; k++) begin
      logic [15:0] x, y;
      x = 16'($urandom);
      y = 16'($urandom);
      if (k % 7 == 0) x = 16'hFFFF;
      apply16(x, y);
      if (p16 !== 32'(32'(x) * 32'(y))) begin
        bad++;
        if (bad <= 4) chk("R1 random w16", 64'(p16), 64'(32'(x) * 32'(y)));
      end
    end
    chk("R1 random mismatch count", 64'(bad), 64'd0);
  endtask

  initial begin
    t_reset();
    t_halves();
    t_extremes();
    t_latency();
    t_example4();
    t_exhaustive8();
    t_random();
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule